// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable integer N = B·P + A and emits one single-cycle pulse per N input cycles. That pulse feeds a phase comparator in a synthesizer loop. The division is built from three parts. A dual-modulus prescaler counts either P or P+1 input cycles. A 6-bit swallow count (A) decides how many of those prescaler periods use the long modulus P+1. A 13-bit main count (B) sets how many prescaler periods make up one output period.

At every output boundary, called the reload point, the block reloads both counts and captures fresh values of A, B and the prescaler select. A change to the inputs in the middle of a period therefore never produces a period with a mixed ratio. Division ratios are contiguous only from P² − P upward; below that, some ratios cannot be formed with B ≥ A.

A counter hold input keeps both counts at their load state for as long as it is high. A configuration with B < 3 or B < A is flagged as an error, and the output is kept silent until a legal setting is captured.

Top module: `pulse_swallow_div`

## Requirements
- R1: The interval between consecutive pulses on `div_o` is exactly B·P + A input cycles, where A and B are the values captured at the reload point that starts the interval.
- R2: `psel_i` selects the base modulus P: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 32, 2'b11 gives 64; the long modulus is always P+1.
- R3: Each pulse on `div_o` is high for exactly one input-clock cycle.
- R4: While `hold_i` is high, `div_o` stays low and both counts sit at their load state. The first cycle with `hold_i` low is cycle 1 of a fresh period, and the pulse appears in cycle N.
- R5: If a configuration with `main_i` < 3 or `main_i` < `swal_i` is captured at a reload point, `cfg_err_o` is high from the next cycle on and `div_o` stays low.
- R6: While `cfg_err_o` is high, the inputs are re-sampled every cycle. The cycle after a legal setting is applied, `cfg_err_o` is low and that cycle is cycle 1 of a period of N cycles.
- R7: Values applied to `psel_i`, `swal_i` or `main_i` after a reload point do not change the current period; they set the length of the following one.
- R8: During reset, `div_o` and `cfg_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock being divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | Holds the counts at their load state while high |
| psel_i | input | 2 | Prescaler base modulus select |
| swal_i | input | 6 | Swallow count A |
| main_i | input | 13 | Main count B |
| div_o | output | 1 | One-cycle pulse every N input cycles |
| cfg_err_o | output | 1 | High while the captured configuration is illegal |

## Verification
A corrupted swallow count or a wrong prescaler terminal shows up at the ports as a pulse interval that is off by a multiple of one cycle or of P. This is visible at the very next pulse after the faulty reload. A main count that misses its last period either stretches the interval by a whole prescaler period or drops the pulse altogether. A wrong capture point shows up as a period of the wrong length directly after a mid-period input change. An error flag that does not re-sample every cycle shows up as a recovery that does not start exactly one cycle after a legal value is applied.

// File: rtl/psdiv_pkg.sv
package psdiv_pkg;
  localparam int A_W   = 6;
  localparam int B_W   = 13;
  localparam int SEL_W = 2;
  localparam int PRE_W = 7;
  localparam int MIN_B = 3;

  function automatic logic [PRE_W-1:0] base_modulus(input logic [SEL_W-1:0] sel);
    base_modulus = PRE_W'(8) << sel;
  endfunction
endpackage

// File: rtl/psdiv_prescaler.sv
module psdiv_prescaler #(
  parameter int PRE_W = psdiv_pkg::PRE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             long_i,
  input  logic [PRE_W-1:0] base_i,
  output logic             tc_o
);
  logic [PRE_W-1:0] cnt_q, cnt_d, top;

  assign top  = long_i ? base_i : base_i - PRE_W'(1);
  assign tc_o = (cnt_q == top);

  always_comb begin
    cnt_d = cnt_q + PRE_W'(1);
    if (restart_i || tc_o) cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/psdiv_swallow.sv
module psdiv_swallow #(
  parameter int A_W = psdiv_pkg::A_W,
  parameter int B_W = psdiv_pkg::B_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           tc_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic           long_o,
  output logic           last_o
);
  logic [A_W-1:0] a_q, a_d;
  logic [B_W-1:0] b_q, b_d;
  logic           step_en;

  assign long_o  = (a_q != '0);
  assign last_o  = (b_q == B_W'(1));
  assign step_en = tc_i && !load_i;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (load_i) begin
      a_d = a_i;
      b_d = b_i;
    end else if (step_en) begin
      if (long_o) a_d = a_q - A_W'(1);
      b_d = b_q - B_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end
endmodule

// File: rtl/psdiv_cfg.sv
module psdiv_cfg
  import psdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [A_W-1:0]   a_i,
  input  logic [B_W-1:0]   b_i,
  output logic [PRE_W-1:0] base_o,
  output logic             err_o,
  output logic             primed_o
);
  logic [PRE_W-1:0] base_q, base_d;
  logic             err_q, err_d, primed_q, bad;

  assign bad = (b_i < B_W'(MIN_B)) || (b_i < B_W'(a_i));

  always_comb begin
    base_d = base_q;
    err_d  = err_q;
    if (load_i) begin
      base_d = base_modulus(sel_i);
      err_d  = bad;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= PRE_W'(8);
      err_q    <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      base_q   <= base_d;
      err_q    <= err_d;
      primed_q <= 1'b1;
    end
  end

  assign base_o   = base_q;
  assign err_o    = err_q;
  assign primed_o = primed_q;
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import psdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic [SEL_W-1:0] psel_i,
  input  logic [A_W-1:0]   swal_i,
  input  logic [B_W-1:0]   main_i,
  output logic             div_o,
  output logic             cfg_err_o
);
  logic [PRE_W-1:0] base;
  logic tc, long_mod, last, err, primed, wrap, load;

  assign wrap = tc && last;
  assign load = !primed || hold_i || err || wrap;

  psdiv_cfg u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
    .sel_i(psel_i), .a_i(swal_i), .b_i(main_i),
    .base_o(base), .err_o(err), .primed_o(primed)
  );

  psdiv_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(load),
    .long_i(long_mod), .base_i(base), .tc_o(tc)
  );

  psdiv_swallow #(.A_W(A_W), .B_W(B_W)) u_swl (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .tc_i(tc),
    .a_i(swal_i), .b_i(main_i), .long_o(long_mod), .last_o(last)
  );

  assign div_o     = wrap && primed && !err && !hold_i;
  assign cfg_err_o = err;
endmodule

// File: rtl/psdiv_chk.sv
module psdiv_chk
  import psdiv_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           hold_i,
  input logic [A_W-1:0] swal_i,
  input logic [B_W-1:0] main_i,
  input logic           div_o,
  input logic           cfg_err_o
);
  p_one_wide_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o);

  p_hold_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> !div_o);

  p_err_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !div_o);

  p_err_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_err_o) |-> $past(main_i < B_W'(MIN_B) || main_i < B_W'(swal_i)));

  p_err_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_err_o) |-> $past(main_i >= B_W'(MIN_B) && main_i >= B_W'(swal_i)));
endmodule

bind pulse_swallow_div psdiv_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold_i), .swal_i(swal_i),
  .main_i(main_i), .div_o(div_o), .cfg_err_o(cfg_err_o)
);

// File: tb/pulse_swallow_div_bench.sv
module pulse_swallow_div_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n, hold;
  logic [1:0]  psel;
  logic [5:0]  swal;
  logic [12:0] main_cnt;
  logic        div, err;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_swallow_div u_pulse_swallow_div (
    .clk_i(clk), .rst_ni(rst_n), .hold_i(hold), .psel_i(psel),
    .swal_i(swal), .main_i(main_cnt), .div_o(div), .cfg_err_o(err)
  );

  function automatic int exp_n(int s, int a, int b);
    return b * (8 << s) + a;
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic set_cfg(int s, int a, int b);
    psel = 2'(s); swal = 6'(a); main_cnt = 13'(b);
  endtask

  task automatic cnt_until_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk); #1;
      n++;
    end while (!div && n < 20000);
  endtask

  task automatic apply_measure(int s, int a, int b, string tag);
    int n;
    set_cfg(s, a, b);
    cnt_until_pulse(n);
    chk(n == exp_n(s, a, b), tag, n, exp_n(s, a, b));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", WATCHDOG, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, seed, seen;
    rst_n = 1'b0; hold = 1'b0;
    set_cfg(0, 0, 3);
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    #1;
    chk(div == 1'b0, "R8 div_o in reset", int'(div), 0);
    chk(err == 1'b0, "R8 cfg_err_o in reset", int'(err), 0);
    rst_n = 1'b1;
    cnt_until_pulse(n);

    // directed ratios, applied at the pulse cycle so they load at its end
    apply_measure(0, 0, 3, "R1 A=0 B=3");
    apply_measure(0, 3, 3, "R1 A=B=3");
    apply_measure(1, 5, 10, "R2 sel 01");
    apply_measure(2, 7, 9, "R2 sel 10");
    apply_measure(3, 1, 4, "R2 sel 11");
    apply_measure(0, 63, 63, "R1 A=B=63");
    apply_measure(0, 0, 3, "R1 back to minimum");

    // R3: pulse lasts one cycle
    @(negedge clk); #1;
    chk(div == 1'b0, "R3 cycle after pulse", int'(div), 0);
    cnt_until_pulse(n);
    chk(n == exp_n(0, 0, 3) - 1, "R3 following interval", n + 1, exp_n(0, 0, 3));

    // constrained random
    for (int i = 0; i < 12; i++) begin
      int s, a, b, amax;
      s = int'($urandom % 4);
      b = 3 + int'($urandom % 38);
      amax = (b < 63) ? b : 63;
      a = int'($urandom % (amax + 1));
      apply_measure(s, a, b, "R1 random");
    end

    // R7: change one cycle after reload; current period keeps old ratio
    set_cfg(1, 2, 5);
    cnt_until_pulse(n);
    @(negedge clk); #1;
    set_cfg(0, 4, 6);
    cnt_until_pulse(n);
    chk(n + 1 == exp_n(1, 2, 5), "R7 current period unchanged", n + 1, exp_n(1, 2, 5));
    cnt_until_pulse(n);
    chk(n == exp_n(0, 4, 6), "R7 next period new ratio", n, exp_n(0, 4, 6));

    // R5: B below minimum
    set_cfg(0, 0, 2);
    @(negedge clk); #1;
    chk(err == 1'b1, "R5 flag for B=2", int'(err), 1);
    seen = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk); #1;
      if (div) seen++;
    end
    chk(seen == 0, "R5 output silent in error", seen, 0);

    // R6: recovery
    set_cfg(0, 1, 4);
    cnt_until_pulse(n);
    chk(n == exp_n(0, 1, 4), "R6 recovery period", n, exp_n(0, 1, 4));
    chk(err == 1'b0, "R6 flag cleared", int'(err), 0);

    // R5: B < A
    set_cfg(0, 10, 5);
    @(negedge clk); #1;
    chk(err == 1'b1, "R5 flag for B<A", int'(err), 1);
    set_cfg(0, 2, 3);
    cnt_until_pulse(n);
    chk(n == exp_n(0, 2, 3), "R6 recovery after B<A", n, exp_n(0, 2, 3));

    // R4: hold
    @(negedge clk); #1;
    hold = 1'b1;
    set_cfg(1, 3, 4);
    seen = 0;
    for (int k = 0; k < 120; k++) begin
      @(negedge clk); #1;
      if (div) seen++;
    end
    chk(seen == 0, "R4 silent during hold", seen, 0);
    hold = 1'b0;
    cnt_until_pulse(n);
    chk(n + 1 == exp_n(1, 3, 4), "R4 first pulse after hold", n + 1, exp_n(1, 3, 4));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule